// File: doc/BRIEF.md
# Outbound Request Screener and Tag Tracker

This block sits between an application that produces memory read and write requests and the transaction-layer core that sends them. Each request descriptor gives a kind, a byte address and a length in DWORDs. The block checks the descriptor against two limits: the configured read-size limit for reads and the configured payload limit for writes. It also checks that the request does not run past the end of its 4 kB page, and that it is well formed. A request that passes goes out on a registered output stage. Reads also carry a tag taken from a pool of 32. A request that fails is consumed and dropped, and a one-cycle rejection pulse with a reason code is raised.

Read completions come back as descriptors carrying a tag, a status, the payload length of this completion in DWORDs and the number of bytes still remaining for the request. Completions are matched against the pool of tags in use. The block reports each matched completion. It frees the tag when the request is finished, either by the final successful completion or by an error status. A completion whose tag is not in use raises a separate flag and changes nothing else.

Both request sides use valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. Once `out_valid` is raised, it and all `out_*` fields hold until `out_ready` is seen high. `req_ready` may depend on the descriptor on the request pins:
- A request that will be rejected is always ready.
- A passing request is ready only when the output stage is empty or draining that cycle.
- A passing read is additionally ready only when a tag is free.

The completion side has no back-pressure: a completion is taken in every cycle that `cpl_valid` is high. The size-limit codes are plain configuration inputs. They are sampled at the moment a request is accepted.

Top module: `req_tag_guard`

## Requirements
- R1: A passing read gets the lowest-numbered tag not in use at the edge where it is accepted, and that tag stays in use until it is retired. Writes carry `out_tag` = 0. Kind encoding: 00 memory read, 01 memory write.
- R2: A read whose byte length (4 × `req_len`) exceeds the read-size limit selected by `mrrs_code` is rejected with code 01.
- R3: A write whose byte length exceeds the payload limit selected by `mps_code` is rejected with code 01.
- R4: A request is rejected with code 10 if (`req_addr` with bits 1:0 cleared, taken modulo 4096) plus 4 × `req_len` exceeds 4096. Address bits 1:0 are ignored.
- R5: A request with `req_len` = 0, or with kind 10 or 11, is rejected with code 11. Precedence among reasons is 11 over 01 over 10.
- R6: A rejected request is accepted (`req_ready` high) and produces no output. `rej_pulse` is high for exactly the one cycle after the accepting edge, with `rej_code` holding the reason. `rej_code` is 00 whenever `rej_pulse` is low.
- R7: Size codes 0 to 5 select 128, 256, 512, 1024, 2048 and 4096 bytes. Codes 6 and 7 select 4096.
- R8: When all 32 tags are in use, `req_ready` is low for a passing read, while writes and rejected requests are still accepted.
- R9: While `out_valid` is high and `out_ready` low, the output fields are held and `req_ready` is low for any passing request. A passing request is accepted in the same cycle `out_ready` drains the stage.
- R10: A completion with status 00 (success) on a tag in use, whose remaining byte count exceeds 4 × `cpl_len`, gives a notice with `note_final` = 0 and `note_err` = 0, and leaves the tag in use.
- R11: A completion with status 00 on a tag in use, whose remaining byte count is at most 4 × `cpl_len`, gives a notice with `note_final` = 1 and frees the tag.
- R12: A completion with status 01 (unsupported request), 10 (completer abort) or 11 (reserved) on a tag in use gives a notice with `note_err` = 1 and `note_final` = 1, and frees the tag whatever the byte count.
- R13: A completion on a tag not in use raises `unexp_pulse` for one cycle, gives no notice and leaves the tag pool unchanged.
- R14: Notices and `unexp_pulse` appear in the cycle after the edge that takes the completion. After reset all tags are free and `out_valid`, `rej_pulse`, `note_valid` and `unexp_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mps_code | input | 3 | Payload size-limit code for writes |
| mrrs_code | input | 3 | Size-limit code for reads |
| req_valid | input | 1 | Request descriptor valid |
| req_ready | output | 1 | Request descriptor accepted this edge |
| req_kind | input | 2 | 00 read, 01 write, others unsupported |
| req_addr | input | 32 | Byte address |
| req_len | input | 11 | Length in DWORDs (0 to 1024) |
| out_valid | output | 1 | Passed request valid |
| out_ready | input | 1 | Downstream takes passed request |
| out_kind | output | 2 | Kind of passed request |
| out_addr | output | 32 | Address of passed request |
| out_len | output | 11 | Length of passed request in DWORDs |
| out_tag | output | 5 | Tag of passed read (0 for writes) |
| rej_pulse | output | 1 | One-cycle rejection strobe |
| rej_code | output | 2 | 01 oversize, 10 page crossing, 11 malformed |
| cpl_valid | input | 1 | Completion descriptor valid |
| cpl_tag | input | 5 | Completion tag |
| cpl_status | input | 2 | 00 success, 01 unsupported request, 10 completer abort, 11 reserved |
| cpl_len | input | 11 | Payload DWORDs in this completion |
| cpl_bcnt | input | 13 | Bytes still remaining, including this completion |
| note_valid | output | 1 | Completion notice strobe |
| note_tag | output | 5 | Tag of the notice |
| note_final | output | 1 | Tag retired by this completion |
| note_err | output | 1 | Completion carried an error status |
| unexp_pulse | output | 1 | Completion tag was not in use |

## Verification
The bench goes after the edges of every limit:
- lengths of exactly the limit and one DWORD over it, for each size code including 6 and 7;
- requests that end exactly on a page end and one DWORD past it;
- descriptors that break several rules at once, to pin the reason precedence.

A design with an off-by-one compare would reject legal requests or pass oversize ones, and one with the wrong precedence would report the wrong code. The bench fills all 32 tags to confirm that reads stall while writes still pass, and that a freed tag is the next one handed out. A design that hands out a tag still in use would show a duplicate tag there. Completion tests split a read into partial pieces, send error statuses and send completions to tags not in use. These catch a tag freed too early, never freed, or changed by an unexpected completion.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam logic [1:0] K_RD = 2'b00;
  localparam logic [1:0] K_WR = 2'b01;

  localparam logic [1:0] REJ_NONE = 2'b00;
  localparam logic [1:0] REJ_SIZE = 2'b01;
  localparam logic [1:0] REJ_PAGE = 2'b10;
  localparam logic [1:0] REJ_FORM = 2'b11;

  localparam logic [1:0] ST_OK = 2'b00;

  localparam int PAGE_BYTES = 4096;
  localparam int MAX_CODE   = 5;

  // Byte limit for a size code; codes above the top one clamp to it.
  function automatic logic [12:0] size_limit(input logic [2:0] code);
    logic [2:0] c;
    c = (code > 3'(MAX_CODE)) ? 3'(MAX_CODE) : code;
    return 13'd128 << c;
  endfunction
endpackage

// File: rtl/rtg_req_check.sv
module rtg_req_check #(
  parameter int LEN_W = 11
) (
  input  logic [1:0]       kind,
  input  logic [9:0]       page_dw,
  input  logic [LEN_W-1:0] len,
  input  logic [2:0]       mps_code,
  input  logic [2:0]       mrrs_code,
  output logic [1:0]       code
);
  import rtg_pkg::*;

  localparam int BYTE_W = LEN_W + 2;
  localparam int END_W  = BYTE_W + 1;

  logic [BYTE_W-1:0] bytes;
  logic [BYTE_W-1:0] limit;
  logic [END_W-1:0]  end_b;
  logic              malformed;
  logic              oversize;
  logic              crosses;

  always_comb begin
    bytes     = {len, 2'b00};
    limit     = BYTE_W'((kind == K_RD) ? size_limit(mrrs_code) : size_limit(mps_code));
    end_b     = END_W'({page_dw, 2'b00}) + END_W'(bytes);
    malformed = (len == '0) || !((kind == K_RD) || (kind == K_WR));
    oversize  = bytes > limit;
    crosses   = end_b > END_W'(PAGE_BYTES);
    if (malformed)     code = REJ_FORM;
    else if (oversize) code = REJ_SIZE;
    else if (crosses)  code = REJ_PAGE;
    else               code = REJ_NONE;
  end
endmodule

// File: rtl/rtg_tag_pool.sv
module rtg_tag_pool #(
  parameter int TAG_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_en,
  input  logic                  ret_en,
  input  logic [TAG_W-1:0]      ret_idx,
  output logic                  any_free,
  output logic [TAG_W-1:0]      pick,
  output logic [(1<<TAG_W)-1:0] free_vec
);
  localparam int NTAGS = 1 << TAG_W;

  logic [NTAGS-1:0] free_q;

  always_comb begin
    pick = '0;
    for (int i = NTAGS - 1; i >= 0; i--) begin
      if (free_q[i]) pick = TAG_W'(i);
    end
  end

  for (genvar g = 0; g < NTAGS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                  free_q[g] <= 1'b1;
      else if (alloc_en && (pick == TAG_W'(g)))    free_q[g] <= 1'b0;
      else if (ret_en && (ret_idx == TAG_W'(g)))   free_q[g] <= 1'b1;
    end
  end

  assign any_free = |free_q;
  assign free_vec = free_q;
endmodule

// File: rtl/rtg_cpl_match.sv
module rtg_cpl_match #(
  parameter int TAG_W = 5,
  parameter int LEN_W = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [(1<<TAG_W)-1:0] free_vec,
  input  logic                  cpl_valid,
  input  logic [TAG_W-1:0]      cpl_tag,
  input  logic [1:0]            cpl_status,
  input  logic [LEN_W-1:0]      cpl_len,
  input  logic [LEN_W+1:0]      cpl_bcnt,
  output logic                  ret_en,
  output logic [TAG_W-1:0]      ret_idx,
  output logic                  note_valid,
  output logic [TAG_W-1:0]      note_tag,
  output logic                  note_final,
  output logic                  note_err,
  output logic                  unexp_pulse
);
  import rtg_pkg::*;

  logic hit;
  logic stray;
  logic is_err;
  logic last_piece;

  always_comb begin
    hit        = cpl_valid && !free_vec[cpl_tag];
    stray      = cpl_valid && free_vec[cpl_tag];
    is_err     = cpl_status != ST_OK;
    last_piece = cpl_bcnt <= {cpl_len, 2'b00};
    ret_en     = hit && (is_err || last_piece);
    ret_idx    = cpl_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      note_valid  <= 1'b0;
      note_tag    <= '0;
      note_final  <= 1'b0;
      note_err    <= 1'b0;
      unexp_pulse <= 1'b0;
    end else begin
      note_valid  <= hit;
      note_tag    <= hit ? cpl_tag : '0;
      note_final  <= hit && (is_err || last_piece);
      note_err    <= hit && is_err;
      unexp_pulse <= stray;
    end
  end
endmodule

// File: rtl/req_tag_guard.sv
module req_tag_guard #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11,
  parameter int TAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mps_code,
  input  logic [2:0]        mrrs_code,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LEN_W-1:0]  out_len,
  output logic [TAG_W-1:0]  out_tag,
  output logic              rej_pulse,
  output logic [1:0]        rej_code,
  input  logic              cpl_valid,
  input  logic [TAG_W-1:0]  cpl_tag,
  input  logic [1:0]        cpl_status,
  input  logic [LEN_W-1:0]  cpl_len,
  input  logic [LEN_W+1:0]  cpl_bcnt,
  output logic              note_valid,
  output logic [TAG_W-1:0]  note_tag,
  output logic              note_final,
  output logic              note_err,
  output logic              unexp_pulse
);
  import rtg_pkg::*;

  localparam int NTAGS = 1 << TAG_W;

  logic [1:0]       chk_code;
  logic             is_rd;
  logic             stage_open;
  logic             accept;
  logic             pass;
  logic             alloc_en;
  logic             any_free;
  logic [TAG_W-1:0] pick;
  logic [NTAGS-1:0] free_vec;
  logic             ret_en;
  logic [TAG_W-1:0] ret_idx;

  rtg_req_check #(.LEN_W(LEN_W)) u_check (
    .kind      (req_kind),
    .page_dw   (req_addr[11:2]),
    .len       (req_len),
    .mps_code  (mps_code),
    .mrrs_code (mrrs_code),
    .code      (chk_code)
  );

  always_comb begin
    is_rd      = req_kind == K_RD;
    stage_open = !out_valid || out_ready;
    if (chk_code != REJ_NONE) req_ready = 1'b1;
    else                      req_ready = stage_open && (!is_rd || any_free);
    accept     = req_valid && req_ready;
    pass       = accept && (chk_code == REJ_NONE);
    alloc_en   = pass && is_rd;
  end

  rtg_tag_pool #(.TAG_W(TAG_W)) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_en (alloc_en),
    .ret_en   (ret_en),
    .ret_idx  (ret_idx),
    .any_free (any_free),
    .pick     (pick),
    .free_vec (free_vec)
  );

  rtg_cpl_match #(.TAG_W(TAG_W), .LEN_W(LEN_W)) u_cpl (
    .clk         (clk),
    .rst_n       (rst_n),
    .free_vec    (free_vec),
    .cpl_valid   (cpl_valid),
    .cpl_tag     (cpl_tag),
    .cpl_status  (cpl_status),
    .cpl_len     (cpl_len),
    .cpl_bcnt    (cpl_bcnt),
    .ret_en      (ret_en),
    .ret_idx     (ret_idx),
    .note_valid  (note_valid),
    .note_tag    (note_tag),
    .note_final  (note_final),
    .note_err    (note_err),
    .unexp_pulse (unexp_pulse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_addr  <= '0;
      out_len   <= '0;
      out_tag   <= '0;
    end else if (pass) begin
      out_valid <= 1'b1;
      out_kind  <= req_kind;
      out_addr  <= req_addr;
      out_len   <= req_len;
      out_tag   <= is_rd ? pick : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rej_pulse <= 1'b0;
      rej_code  <= REJ_NONE;
    end else begin
      rej_pulse <= accept && (chk_code != REJ_NONE);
      rej_code  <= accept ? chk_code : REJ_NONE;
    end
  end
endmodule

// File: rtl/rtg_props.sv
module rtg_props #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11,
  parameter int TAG_W  = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [1:0]            out_kind,
  input logic [ADDR_W-1:0]     out_addr,
  input logic [LEN_W-1:0]      out_len,
  input logic [TAG_W-1:0]      out_tag,
  input logic [(1<<TAG_W)-1:0] free_vec,
  input logic                  rej_pulse,
  input logic [1:0]            rej_code,
  input logic                  note_valid,
  input logic [TAG_W-1:0]      note_tag,
  input logic                  note_final,
  input logic                  note_err,
  input logic                  unexp_pulse
);
  localparam int SUM_W = LEN_W + 2;

  p_read_tag_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_kind == 2'b00) |-> !free_vec[out_tag]);

  p_no_page_cross_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (SUM_W'(out_addr[11:2]) + SUM_W'(out_len)) <= SUM_W'(1024));

  p_well_formed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len != '0) && (out_kind[1] == 1'b0));

  p_rej_has_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rej_pulse |-> rej_code != 2'b00);

  p_rej_code_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rej_pulse |-> rej_code == 2'b00);

  p_hold_output_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_len)
                                && $stable(out_tag) && $stable(out_kind));

  p_partial_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid && !note_final |-> !free_vec[note_tag]);

  p_final_frees_r11: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid && note_final |-> free_vec[note_tag]);

  p_err_is_final_r12: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid && note_err |-> note_final);

  p_stray_alone_r13: assert property (@(posedge clk) disable iff (!rst_n)
    unexp_pulse |-> !note_valid);
endmodule

bind req_tag_guard rtg_props #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_W(TAG_W)) u_props (
  .clk         (clk),
  .rst_n       (rst_n),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_kind    (out_kind),
  .out_addr    (out_addr),
  .out_len     (out_len),
  .out_tag     (out_tag),
  .free_vec    (free_vec),
  .rej_pulse   (rej_pulse),
  .rej_code    (rej_code),
  .note_valid  (note_valid),
  .note_tag    (note_tag),
  .note_final  (note_final),
  .note_err    (note_err),
  .unexp_pulse (unexp_pulse)
);

// File: tb/tb_req_tag_guard.sv
`timescale 1ns/1ps
module tb_req_tag_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mps_code = 3'd0;
  logic [2:0]  mrrs_code = 3'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'b00;
  logic [31:0] req_addr = '0;
  logic [10:0] req_len = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_kind;
  logic [31:0] out_addr;
  logic [10:0] out_len;
  logic [4:0]  out_tag;
  logic        rej_pulse;
  logic [1:0]  rej_code;
  logic        cpl_valid = 1'b0;
  logic [4:0]  cpl_tag = '0;
  logic [1:0]  cpl_status = '0;
  logic [10:0] cpl_len = '0;
  logic [12:0] cpl_bcnt = '0;
  logic        note_valid;
  logic [4:0]  note_tag;
  logic        note_final;
  logic        note_err;
  logic        unexp_pulse;

  int checks = 0;
  int errors = 0;
  logic [31:0] bfree = '1;

  always #4 clk = ~clk;

  req_tag_guard dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lowest_free(input logic [31:0] f);
    for (int i = 31; i >= 0; i--) if (f[i]) lowest_free = i;
    if (f == 0) lowest_free = -1;
  endfunction

  function automatic int lim_bytes(input int code);
    int c;
    c = (code > 5) ? 5 : code;
    return 128 << c;
  endfunction

  function automatic int exp_code(input int k, input logic [31:0] a, input int len,
                                  input int mps, input int mrrs);
    if (len == 0 || k > 1) return 3;
    if (len * 4 > lim_bytes(k == 0 ? mrrs : mps)) return 1;
    if (int'(a & 32'hFFC) + len * 4 > 4096) return 2;
    return 0;
  endfunction

  // Drives one request to acceptance and checks the registered result.
  task automatic do_req(input logic [1:0] k, input logic [31:0] a, input int len, input string req);
    int ec;
    int et;
    ec = exp_code(k, a, len, mps_code, mrrs_code);
    et = lowest_free(bfree);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_len = 11'(len);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    if (ec != 0) begin
      chk(rej_pulse == 1'b1 && int'(rej_code) == ec, req, rej_code, ec);
      chk(out_valid == 1'b0, {req, " R6 no output"}, out_valid, 0);
    end else begin
      chk(out_valid == 1'b1 && rej_pulse == 1'b0, req, out_valid, 1);
      chk(out_addr == a && int'(out_len) == len && out_kind == k, {req, " fields"}, out_addr, a);
      if (k == 2'b00) begin
        chk(int'(out_tag) == et, {req, " R1 tag"}, out_tag, et);
        bfree[et] = 1'b0;
      end else begin
        chk(out_tag == 5'd0, {req, " R1 write tag"}, out_tag, 0);
      end
    end
  endtask

  task automatic do_cpl(input int t, input int st, input int len, input int bc, input string req);
    bit used;
    bit fin;
    used = !bfree[t];
    fin = (st != 0) || (bc <= len * 4);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_tag = 5'(t); cpl_status = 2'(st); cpl_len = 11'(len); cpl_bcnt = 13'(bc);
    @(posedge clk); #1;
    cpl_valid = 1'b0;
    @(negedge clk);
    if (!used) begin
      chk(unexp_pulse == 1'b1 && note_valid == 1'b0, {req, " R13"}, unexp_pulse, 1);
    end else begin
      chk(note_valid && !unexp_pulse && int'(note_tag) == t, req, note_tag, t);
      chk(note_final == fin && note_err == (st != 0), {req, " flags"},
          {note_final, note_err}, {fin, st != 0});
      if (fin) bfree[t] = 1'b1;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r;
    int t;
    int l;
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R14 reset state
    chk(!out_valid && !rej_pulse && !note_valid && !unexp_pulse, "R14 reset outputs",
        {out_valid, rej_pulse, note_valid, unexp_pulse}, 0);

    // R7 size codes: exact limit passes, one DWORD over is rejected
    for (int c = 0; c < 8; c++) begin
      mrrs_code = 3'(c); mps_code = 3'(7 - c);
      do_req(2'b00, 32'h1000_0000, lim_bytes(c) / 4, "R7 R2 read at limit");
      do_req(2'b00, 32'h1000_0000, lim_bytes(c) / 4 + 1, "R7 R2 read over limit");
      do_req(2'b01, 32'h2000_0000, lim_bytes(7 - c) / 4, "R7 R3 write at limit");
      do_req(2'b01, 32'h2000_0000, lim_bytes(7 - c) / 4 + 1, "R7 R3 write over limit");
      do_cpl(lowest_free(~bfree), 0, 1, 4, "R11 free read");
    end

    // R4 page end
    mps_code = 3'd5; mrrs_code = 3'd5;
    do_req(2'b01, 32'h0000_0F00, 64, "R4 ends on page end");
    do_req(2'b01, 32'h0000_0F03, 65, "R4 one DWORD past");
    do_req(2'b01, 32'h0000_0004, 1024, "R4 full page shifted");
    // R5 malformed and precedence
    do_req(2'b10, 32'h0, 4, "R5 kind 10");
    do_req(2'b11, 32'h0, 4, "R5 kind 11");
    do_req(2'b00, 32'h0, 0, "R5 zero length");
    mrrs_code = 3'd0;
    do_req(2'b00, 32'h0000_0FF0, 64, "R5 size over page precedence");
    do_req(2'b10, 32'h0000_0FF0, 64, "R5 form over size precedence");
    mrrs_code = 3'd5;

    // R10 partial then R11 final
    do_req(2'b00, 32'h3000_0000, 64, "R1 read for split");
    t = lowest_free(~bfree);
    do_cpl(t, 0, 32, 256, "R10 partial");
    chk(!bfree[t], "R10 tag kept", bfree[t], 0);
    do_req(2'b00, 32'h3000_1000, 8, "R10 R1 new read skips held tag");
    do_cpl(t, 0, 32, 128, "R11 final piece");
    // R12 error statuses
    do_cpl(0, 0, 0, 4, "R11 retire 0");
    do_req(2'b00, 32'h3000_2000, 8, "R1 reuse");
    do_cpl(0, 1, 1, 4000, "R12 UR retires");
    do_cpl(0, 2, 1, 4, "R13 after UR");
    do_req(2'b00, 32'h3000_3000, 8, "R1 tag for CA");
    do_cpl(0, 2, 0, 4000, "R12 CA retires");
    // R13 stray leaves state: next read still gets tag 0
    do_cpl(17, 0, 1, 4, "R13 stray tag");
    do_req(2'b00, 32'h3000_4000, 8, "R13 R1 pool unchanged");
    for (int i = 0; i < 32; i++) if (!bfree[i]) do_cpl(i, 3, 1, 4, "R12 reserved status");

    // R8 exhaustion
    for (int i = 0; i < 32; i++) do_req(2'b00, 32'h4000_0000 + 32'(i * 64), 4, "R8 fill");
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b00; req_addr = 32'h5000_0000; req_len = 11'd4;
    #1 chk(req_ready == 1'b0, "R8 read stalls when full", req_ready, 0);
    req_kind = 2'b11;
    #1 chk(req_ready == 1'b1, "R8 reject still taken", req_ready, 1);
    req_valid = 1'b0;
    do_req(2'b01, 32'h5000_0000, 4, "R8 write still flows");
    do_cpl(9, 0, 1, 4, "R11 free tag 9");
    do_req(2'b00, 32'h5000_0100, 4, "R8 R1 freed tag reused");
    for (int i = 0; i < 32; i++) if (!bfree[i]) do_cpl(i, 0, 1, 4, "R11 drain");

    // R9 back-pressure
    out_ready = 1'b0;
    do_req(2'b01, 32'h6000_0000, 4, "R9 first write");
    @(negedge clk);
    chk(out_valid && out_addr == 32'h6000_0000, "R9 held", out_addr, 32'h6000_0000);
    req_valid = 1'b1; req_kind = 2'b01; req_addr = 32'h6000_0040; req_len = 11'd2;
    #1 chk(req_ready == 1'b0, "R9 ready low when full", req_ready, 0);
    @(negedge clk);
    chk(out_addr == 32'h6000_0000, "R9 still held", out_addr, 32'h6000_0000);
    out_ready = 1'b1;
    #1 chk(req_ready == 1'b1, "R9 ready on drain", req_ready, 1);
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    chk(out_valid && out_addr == 32'h6000_0040, "R9 next loaded", out_addr, 32'h6000_0040);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      mps_code = 3'($urandom % 8); mrrs_code = 3'($urandom % 8);
      r = $urandom % 10;
      case ($urandom % 4)
        0: l = $urandom % 1025;
        1: l = lim_bytes(r < 5 ? mrrs_code : mps_code) / 4;
        2: l = lim_bytes(r < 5 ? mrrs_code : mps_code) / 4 + 1;
        default: l = 1 + $urandom % 32;
      endcase
      if (lowest_free(bfree) < 0) do_cpl(lowest_free(~bfree), 0, 1, 4, "R11 random drain");
      do_req(r < 5 ? 2'b00 : (r < 9 ? 2'b01 : 2'($urandom % 4)),
             {$urandom} & ((r % 2) ? 32'hFFFF_FFFF : 32'hFFFF_FF80 | 32'h0000_0F00),
             l, "R2 R3 R4 R5 random request");
      if ($urandom % 3 == 0) begin
        t = $urandom % 32;
        l = 1 + $urandom % 64;
        do_cpl(t, ($urandom % 4 == 0) ? int'($urandom % 4) : 0, l,
               ($urandom % 2) ? l * 4 : l * 4 + 4, "R10 R11 R12 R13 random completion");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule